// File: doc/BRIEF.md
# Serial Configuration Receiver with Startup Sequencer

This block is the receiving end of a passive serial configuration link. An upstream source shifts a bitstream into it one bit per rising edge of an externally driven configuration clock. The block counts the bits and, once the expected length has arrived, releases an open-drain done line. That line goes high, and because it also drives the source's active-low chip select, it shuts the source off. The block then runs a startup count of initialization clock ticks and enters user mode.

Two option bits in the first frame of the bitstream set the behaviour of the startup phase. One enables an open-drain init-done line. This line is driven low from the moment its enable bit arrives and is released when user mode begins. The other option bit selects the initialization clock. The default is an internal oscillator, modelled as a tick every `OSC_DIV` system cycles. The alternative is a user clock pin, whose edges are ignored for `DLY_CYC` cycles after done rises.

All inputs are sampled by `clk_i`. The configuration clock and the user clock pass through two-flop synchronizers and a rising-edge detector. `cfg_req_ni` is treated as synchronous to `clk_i`. Bits are numbered 0 upward in the order they are received.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset, and in any cycle in which `cfg_req_ni` was low on the previous edge, the outputs read as follows: `done_o` low (`done_oe_o` high), `status_o` low, `initdone_o` high (`initdone_oe_o` low), `user_mode_o` low and `bit_cnt_o` zero.
- R2: While `status_o` is high and fewer than `BS_LEN` bits have arrived, each rising edge of `cfg_clk_i` captures `data_i` and raises `bit_cnt_o` by one. Falling edges and a steady clock leave `bit_cnt_o` unchanged.
- R3: `done_o` stays low until `bit_cnt_o` equals `BS_LEN`, then reads high (not driven). Further clock edges after that leave `bit_cnt_o` at `BS_LEN`.
- R4: If the configuration clock stops before `BS_LEN` bits have arrived, `done_o` stays low and `bit_cnt_o` holds the number of bits received.
- R5: If received bit number `IDONE_BIT` is 1, `initdone_o` is driven low from the cycle after that bit is counted until user mode. If that bit is 0, and in every cycle before it arrives, `initdone_o` reads high.
- R6: If received bit number `UCLK_BIT` is 0, the startup count runs on the internal oscillator, one tick per `OSC_DIV` cycles of `clk_i`. `user_mode_o` rises between 298·`OSC_DIV` and 299·`OSC_DIV`+8 cycles after `done_o` rises.
- R7: If received bit number `UCLK_BIT` is 1, the startup count uses only rising edges of `usr_clk_i`. Edges during the first `DLY_CYC` cycles after done, and oscillator ticks, have no effect.
- R8: User mode starts on exactly the `INIT_CYC`-th (299th) counted initialization tick, never earlier. At that point `user_mode_o` rises and `initdone_o` is released high.
- R9: Driving `cfg_req_ni` low in any phase clears the bit counter, the options and the startup counts, holds `done_o` low, and returns the block to waiting.
- R10: If an abort falls in the same cycle as the capture of the final bit, the abort wins: `bit_cnt_o` is zero and `done_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock sampling all inputs |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_req_ni | input | 1 | Active-low configuration request / abort |
| cfg_clk_i | input | 1 | Serial configuration clock from the source |
| data_i | input | 1 | Serial configuration data |
| usr_clk_i | input | 1 | Optional user initialization clock |
| status_o | output | 1 | High while a transfer is allowed; drives the source output enable |
| done_oe_o | output | 1 | Open-drain pull-down enable of the done line |
| done_o | output | 1 | Level of the done line (high when not driven) |
| initdone_oe_o | output | 1 | Open-drain pull-down enable of the init-done line |
| initdone_o | output | 1 | Level of the init-done line (high when not driven) |
| user_mode_o | output | 1 | High once startup has finished |
| bit_cnt_o | output | $clog2(BS_LEN+1) | Number of bits accepted so far |

## Verification
Two events can land in the same cycle: an abort on `cfg_req_ni` and the synchronized capture of the final bitstream bit. The bench lowers `cfg_req_ni` just before the clock edge on which the last edge reaches the counter, which is three system cycles after `cfg_clk_i` rises. It then requires a zero bit count and a low done line, with no user mode afterwards. User-clock edges that fall inside the post-done delay are also judged at the ports. After the delay the bench supplies exactly 298 edges, expects no user mode, and expects user mode after the 299th.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  typedef enum logic [2:0] {
    ST_WAIT,
    ST_RECV,
    ST_DLY,
    ST_INIT,
    ST_USER
  } cfg_state_e;
endpackage

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], sig_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cfg_shift_rx.sv
module cfg_shift_rx #(
  parameter int BS_LEN    = 32,
  parameter int FRAME_W   = 8,
  parameter int IDONE_BIT = 2,
  parameter int UCLK_BIT  = 5,
  localparam int CNT_W    = $clog2(BS_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             stb_i,
  input  logic             data_i,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic             full_o,
  output logic             opt_idone_o,
  output logic             opt_uclk_o
);
  logic take;

  assign full_o = (bit_cnt_o == CNT_W'(BS_LEN));
  assign take   = en_i & stb_i & ~full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_o   <= '0;
      opt_idone_o <= 1'b0;
      opt_uclk_o  <= 1'b0;
    end else if (clr_i) begin
      bit_cnt_o   <= '0;
      opt_idone_o <= 1'b0;
      opt_uclk_o  <= 1'b0;
    end else if (take) begin
      bit_cnt_o <= bit_cnt_o + 1'b1;
      if (bit_cnt_o == CNT_W'(IDONE_BIT)) opt_idone_o <= data_i;
      if (bit_cnt_o == CNT_W'(UCLK_BIT))  opt_uclk_o  <= data_i;
    end
  end

  initial begin
    if (IDONE_BIT >= FRAME_W || UCLK_BIT >= FRAME_W || FRAME_W > BS_LEN)
      $error("option bits must sit inside the first frame");
  end

  // R2: count moves by one or clears
  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt_o != $past(bit_cnt_o)) |->
      (bit_cnt_o == $past(bit_cnt_o) + 1'b1 || bit_cnt_o == '0));

  // R3: never beyond the bitstream length
  a_r3_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(full_o) && !$past(clr_i) |-> $stable(bit_cnt_o));
endmodule

// File: rtl/cfg_startup.sv
module cfg_startup #(
  parameter int INIT_CYC = 299,
  parameter int OSC_DIV  = 4,
  parameter int DLY_CYC  = 64,
  localparam int INIT_W  = $clog2(INIT_CYC + 1),
  localparam int DLY_W   = $clog2(DLY_CYC + 1),
  localparam int OSC_W   = $clog2(OSC_DIV)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic dly_en_i,
  input  logic init_en_i,
  input  logic use_usr_i,
  input  logic usr_tick_i,
  output logic dly_done_o,
  output logic init_done_o
);
  logic [OSC_W-1:0]  osc_q;
  logic [DLY_W-1:0]  dly_q;
  logic [INIT_W-1:0] init_q;
  logic              osc_tick;
  logic              tick;

  // free-running internal oscillator model
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) osc_q <= '0;
    else if (osc_q == OSC_W'(OSC_DIV - 1)) osc_q <= '0;
    else osc_q <= osc_q + 1'b1;
  end
  assign osc_tick = (osc_q == OSC_W'(OSC_DIV - 1));

  assign tick        = init_en_i & (use_usr_i ? usr_tick_i : osc_tick);
  assign dly_done_o  = dly_en_i & (dly_q == DLY_W'(DLY_CYC - 1));
  assign init_done_o = tick & (init_q == INIT_W'(INIT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q  <= '0;
      init_q <= '0;
    end else if (clr_i) begin
      dly_q  <= '0;
      init_q <= '0;
    end else begin
      if (dly_en_i && !dly_done_o) dly_q <= dly_q + 1'b1;
      if (tick && !init_done_o)    init_q <= init_q + 1'b1;
    end
  end

  // R8: startup count stays below its limit
  a_r8_init_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q < INIT_W'(INIT_CYC));

  // R7: no ticks counted while the delay is running
  a_r7_no_tick_in_dly: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_en_i && !clr_i |=> init_q == '0);
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
  import cfg_rx_pkg::*;
#(
  parameter int BS_LEN    = 32,
  parameter int FRAME_W   = 8,
  parameter int IDONE_BIT = 2,
  parameter int UCLK_BIT  = 5,
  parameter int INIT_CYC  = 299,
  parameter int OSC_DIV   = 4,
  parameter int DLY_CYC   = 64,
  localparam int CNT_W    = $clog2(BS_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_req_ni,
  input  logic             cfg_clk_i,
  input  logic             data_i,
  input  logic             usr_clk_i,
  output logic             status_o,
  output logic             done_oe_o,
  output logic             done_o,
  output logic             initdone_oe_o,
  output logic             initdone_o,
  output logic             user_mode_o,
  output logic [CNT_W-1:0] bit_cnt_o
);
  cfg_state_e state_q, state_d;
  logic cfg_rise, usr_rise;
  logic full, opt_idone, opt_uclk;
  logic dly_done, init_done;
  logic abort;

  assign abort = ~cfg_req_ni;

  cfg_edge_sync #(.STAGES(2)) u_cfg_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .sig_i(cfg_clk_i), .rise_o(cfg_rise));

  cfg_edge_sync #(.STAGES(2)) u_usr_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .sig_i(usr_clk_i), .rise_o(usr_rise));

  cfg_shift_rx #(
    .BS_LEN(BS_LEN), .FRAME_W(FRAME_W), .IDONE_BIT(IDONE_BIT), .UCLK_BIT(UCLK_BIT)
  ) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (abort),
    .en_i       (state_q == ST_RECV),
    .stb_i      (cfg_rise),
    .data_i     (data_i),
    .bit_cnt_o  (bit_cnt_o),
    .full_o     (full),
    .opt_idone_o(opt_idone),
    .opt_uclk_o (opt_uclk)
  );

  cfg_startup #(
    .INIT_CYC(INIT_CYC), .OSC_DIV(OSC_DIV), .DLY_CYC(DLY_CYC)
  ) u_start (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (abort),
    .dly_en_i   (state_q == ST_DLY),
    .init_en_i  (state_q == ST_INIT),
    .use_usr_i  (opt_uclk),
    .usr_tick_i (usr_rise),
    .dly_done_o (dly_done),
    .init_done_o(init_done)
  );

  always_comb begin
    state_d = state_q;
    if (abort) state_d = ST_WAIT;
    else begin
      unique case (state_q)
        ST_WAIT: state_d = ST_RECV;
        ST_RECV: if (full) state_d = opt_uclk ? ST_DLY : ST_INIT;
        ST_DLY:  if (dly_done) state_d = ST_INIT;
        ST_INIT: if (init_done) state_d = ST_USER;
        ST_USER: state_d = ST_USER;
        default: state_d = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_WAIT;
    else         state_q <= state_d;
  end

  assign status_o      = (state_q != ST_WAIT);
  assign done_oe_o     = (state_q == ST_WAIT) || (state_q == ST_RECV);
  assign done_o        = ~done_oe_o;
  assign initdone_oe_o = opt_idone && (state_q != ST_USER) && (state_q != ST_WAIT);
  assign initdone_o    = ~initdone_oe_o;
  assign user_mode_o   = (state_q == ST_USER);

  // R3: done only with a complete bitstream
  a_r3_done_needs_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> bit_cnt_o == CNT_W'(BS_LEN));

  // R9: abort clears counter and done
  a_r9_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_req_ni |=> (bit_cnt_o == '0) && !done_o && !status_o);

  // R8: user mode implies init-done released
  a_r8_user_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_mode_o |-> initdone_o && done_o);

  // R8: user mode only entered from the startup count
  a_r8_user_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(user_mode_o) |-> $past(state_q) == ST_INIT);
endmodule

// File: tb/tb_cfg_serial_rx.sv
module tb_cfg_serial_rx;
  localparam int BS_LEN = 32, FRAME_W = 8, IDONE_BIT = 2, UCLK_BIT = 5;
  localparam int INIT_CYC = 299, OSC_DIV = 4, DLY_CYC = 64;
  localparam int CNT_W = $clog2(BS_LEN + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_req_ni = 1'b1, cfg_clk = 1'b0, data = 1'b0, usr_clk = 1'b0;
  logic status, done_oe, done, idone_oe, idone, user_mode;
  logic [CNT_W-1:0] bit_cnt;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  cfg_serial_rx #(
    .BS_LEN(BS_LEN), .FRAME_W(FRAME_W), .IDONE_BIT(IDONE_BIT), .UCLK_BIT(UCLK_BIT),
    .INIT_CYC(INIT_CYC), .OSC_DIV(OSC_DIV), .DLY_CYC(DLY_CYC)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_req_ni(cfg_req_ni), .cfg_clk_i(cfg_clk),
    .data_i(data), .usr_clk_i(usr_clk), .status_o(status), .done_oe_o(done_oe),
    .done_o(done), .initdone_oe_o(idone_oe), .initdone_o(idone),
    .user_mode_o(user_mode), .bit_cnt_o(bit_cnt)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_idone(logic [BS_LEN-1:0] s, int sent);
    return (sent > IDONE_BIT && s[IDONE_BIT]) ? 0 : 1;
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); data = b; cfg_clk = 1'b1;
    wait_cyc(3); cfg_clk = 1'b0; wait_cyc(3);
  endtask

  task automatic usr_pulse();
    @(negedge clk); usr_clk = 1'b1;
    wait_cyc(3); usr_clk = 1'b0; wait_cyc(3);
  endtask

  task automatic restart();
    @(negedge clk); cfg_req_ni = 1'b0; wait_cyc(2);
    cfg_req_ni = 1'b1; wait_cyc(2);
  endtask

  task automatic send_stream(logic [BS_LEN-1:0] s);
    for (int i = 0; i < BS_LEN; i++) send_bit(s[i]);
  endtask

  task automatic run_osc(logic [BS_LEN-1:0] s);
    s[UCLK_BIT] = 1'b0;
    restart();
    send_stream(s);
    chk("R3 done after full length", done, 1);
    chk("R5 initdone during startup", idone, exp_idone(s, BS_LEN));
    wait_cyc(298 * OSC_DIV - 8);
    chk("R6 no user mode before 298 osc ticks", user_mode, 0);
    wait_cyc(OSC_DIV + 16);
    chk("R6 user mode on oscillator", user_mode, 1);
    chk("R8 initdone released in user mode", idone, 1);
  endtask

  initial begin
    logic [BS_LEN-1:0] s;
    void'($urandom(32'd1234));
    wait_cyc(3);
    chk("R1 reset done", done, 0);
    chk("R1 reset status", status, 0);
    chk("R1 reset initdone", idone, 1);
    chk("R1 reset user mode", user_mode, 0);
    chk("R1 reset count", bit_cnt, 0);
    rst_ni = 1'b1;
    wait_cyc(3);

    // R2 / R5: partial stream, init-done enable bit observed
    s = $urandom();
    s[IDONE_BIT] = 1'b1;
    for (int i = 0; i < IDONE_BIT; i++) send_bit(s[i]);
    chk("R5 initdone before enable bit", idone, 1);
    chk("R2 count after partial", bit_cnt, IDONE_BIT);
    send_bit(s[IDONE_BIT]);
    chk("R5 initdone driven low", idone, 0);
    // R2: falling edge only / steady clock
    @(negedge clk); cfg_clk = 1'b1; wait_cyc(6);
    chk("R2 one count per rising edge", bit_cnt, IDONE_BIT + 2);
    cfg_clk = 1'b0; wait_cyc(6);
    chk("R2 falling edge ignored", bit_cnt, IDONE_BIT + 2);
    // R4: clock stops
    wait_cyc(500);
    chk("R4 done stays low", done, 0);
    chk("R4 count holds", bit_cnt, IDONE_BIT + 2);

    // R9: abort mid-stream
    @(negedge clk); cfg_req_ni = 1'b0; @(negedge clk);
    chk("R9 abort clears count", bit_cnt, 0);
    chk("R9 abort initdone released", idone, 1);
    chk("R1 status low while request low", status, 0);
    cfg_req_ni = 1'b1; wait_cyc(2);

    // R6/R5: random streams on oscillator
    for (int k = 0; k < 3; k++) begin
      s = $urandom();
      if (k == 0) s[IDONE_BIT] = 1'b0;
      run_osc(s);
    end

    // R3: extra edges after done ignored
    send_bit(1'b1); send_bit(1'b0);
    chk("R3 extra edges ignored", bit_cnt, BS_LEN);

    // R9: abort from user mode
    restart();
    chk("R9 abort leaves user mode", user_mode, 0);
    chk("R9 abort pulls done low", done, 0);

    // R7/R8: user clock path
    s = $urandom();
    s[UCLK_BIT] = 1'b1;
    s[IDONE_BIT] = 1'b1;
    send_stream(s);
    chk("R3 done with user clock", done, 1);
    for (int i = 0; i < 5; i++) usr_pulse();
    wait_cyc(DLY_CYC + 400);
    chk("R7 edges in delay and osc ignored", user_mode, 0);
    for (int i = 0; i < INIT_CYC - 1; i++) usr_pulse();
    chk("R8 no user mode after 298 edges", user_mode, 0);
    chk("R5 initdone still low", idone, 0);
    usr_pulse();
    chk("R8 user mode on 299th edge", user_mode, 1);
    chk("R8 initdone released", idone, 1);

    // R10: abort coincides with final bit capture
    restart();
    send_stream(s >> 1);
    for (int i = 0; i < BS_LEN - 1; i++) ; // count already at BS_LEN? no: restart below
    restart();
    for (int i = 0; i < BS_LEN - 1; i++) send_bit(s[i]);
    chk("R10 count before last bit", bit_cnt, BS_LEN - 1);
    @(negedge clk); cfg_clk = 1'b1; data = s[BS_LEN-1];
    wait_cyc(2);
    cfg_req_ni = 1'b0;
    @(negedge clk);
    chk("R10 abort wins count", bit_cnt, 0);
    chk("R10 abort wins done", done, 0);
    cfg_clk = 1'b0; cfg_req_ni = 1'b1;
    wait_cyc(1500);
    chk("R10 no user mode after collision", user_mode, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule